// File: doc/BRIEF.md
# Quasi-Bidirectional Port Controller

This block is an eight-bit general-purpose port with no direction register. Every pin has one output latch bit, and that bit alone decides how the pin is driven. A latch bit of 0 turns on a strong pulldown that can sink current. A latch bit of 1 turns off the pulldown and leaves a weak pull-up, so an external device can pull the pin low. Software reads such a pin as an input. When a bit goes from 0 to 1, a strong pull-up also turns on for a fixed number of clock cycles. This lets the line rise quickly before the weak pull-up alone holds it. Input pins and output pins can be mixed freely on the same port.

The CPU side has a single command port with four operations: a plain write of the latch, an AND of the latch with an operand, an OR of the latch with an operand, and a read of the pins. The AND and OR operations take the latch contents, not the pin levels, so that single pins can be set or cleared without disturbing the others. A read returns the resolved pin levels after a two-flop synchronizer. The pads are outside the block. It produces three drive-enable vectors and takes back the resolved pin level.

Each pin is governed by its own three-state machine:
- `PS_LOW`: latch 0, pulldown on.
- `PS_BOOST`: latch 1, strong and weak pull-up on, a cycle counter running.
- `PS_WEAK`: latch 1, weak pull-up only.

The transitions are:
- `LOW->BOOST` when a 1 is stored.
- `BOOST->WEAK` when the counter expires.
- `BOOST->LOW` and `WEAK->LOW` when a 0 is stored.
- `BOOST->BOOST` while counting. A 1 stored again does not reload the counter.
- `WEAK->WEAK` and `LOW->LOW` as holds.

Reset enters `PS_WEAK` for every bit.

Top module: `qbp_port`

## Requirements
- R1: After reset every bit is in the weak-high state: `pull_weak` is all ones, `pull_down` and `pull_strong` are all zeros, and `rd_valid` is 0.
- R2: A write command (`cmd_op` = 2'b00) stores `cmd_data` into the latch. From the cycle after the command, every bit written 0 has `pull_down` = 1 and `pull_weak` = 0.
- R3: A bit whose latch goes from 0 to 1 has `pull_strong` = 1 for exactly PULSE_CYC consecutive cycles, starting the cycle after the command. During those cycles `pull_weak` = 1 and `pull_down` = 0. Afterwards only `pull_weak` stays on.
- R4: Storing 1 into a bit that is already 1 starts no pulse. If the bit is in its pulse, the pulse is not restarted and ends at its original time. Other bits of the same command that rise from 0 start their own full pulse.
- R5: Storing 0 into a bit during its pulse ends the pulse in the next cycle and turns on the pulldown. `pull_strong` and `pull_down` are never both 1 on the same bit.
- R6: An AND command (`cmd_op` = 2'b01) sets the latch to latch AND `cmd_data`.
- R7: An OR command (`cmd_op` = 2'b10) sets the latch to latch OR `cmd_data`. The latch is the operand, even when an external device holds a latched-1 pin low. The same holds for AND.
- R8: A read command (`cmd_op` = 2'b11) pulses `rd_valid` for one cycle, in the cycle after the command. `rd_data` then holds the pin levels as they stood two clock edges before the command edge, one bit per pin at the same position.
- R9: Bits are independent. A pin with latch 1 reads back the level an external device applies while other pins of the port drive low.
- R10: A read command, or any cycle with `cmd_valid` = 0, leaves the latch and all drive outputs unchanged and starts no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 00 write, 01 AND, 10 OR, 11 read |
| cmd_data | input | W | Write value or logical operand |
| rd_valid | output | 1 | Read data valid, one cycle after a read |
| rd_data | output | W | Synchronized pin levels |
| pin_in | input | W | Resolved pin levels from the pads |
| pull_weak | output | W | Weak pull-up enable per pin |
| pull_strong | output | W | Momentary strong pull-up enable per pin |
| pull_down | output | W | Strong pulldown enable per pin |

## Verification
If a bit's state machine ends up in the wrong state, the fault shows on the drive vectors in the cycle right after the command that caused it. A wrong state drives `pull_down` against a pin meant to float high, or leaves `pull_strong` on too long. A wrong counter shows up only at the end of a pulse, PULSE_CYC cycles later. So the bench measures pulse length to the cycle, for both fresh pulses and pulses that receive a second write. A latch operand taken from the pins instead of the latch shows only when an external device holds a latched-1 pin low. The bench creates exactly that case before each logical update.

// File: rtl/qbp_pkg.sv
package qbp_pkg;

    typedef enum logic [1:0] {
        OP_WRITE = 2'b00,
        OP_AND   = 2'b01,
        OP_OR    = 2'b10,
        OP_READ  = 2'b11
    } port_op_e;

    typedef enum logic [1:0] {
        PS_WEAK  = 2'b00,
        PS_BOOST = 2'b01,
        PS_LOW   = 2'b10
    } pin_st_e;

endpackage

// File: rtl/qbp_cmd.sv
module qbp_cmd #(
    parameter int W = 8
) (
    input  logic         cmd_valid,
    input  logic [1:0]   cmd_op,
    input  logic [W-1:0] cmd_data,
    input  logic [W-1:0] latch_q,
    output logic         upd_en,
    output logic         rd_req,
    output logic [W-1:0] latch_nxt
);
    import qbp_pkg::*;

    port_op_e op;

    always_comb begin
        op        = port_op_e'(cmd_op);
        upd_en    = 1'b0;
        rd_req    = 1'b0;
        latch_nxt = latch_q;
        if (cmd_valid) begin
            unique case (op)
                OP_WRITE: begin
                    upd_en    = 1'b1;
                    latch_nxt = cmd_data;
                end
                OP_AND: begin
                    upd_en    = 1'b1;
                    latch_nxt = latch_q & cmd_data;
                end
                OP_OR: begin
                    upd_en    = 1'b1;
                    latch_nxt = latch_q | cmd_data;
                end
                OP_READ: begin
                    rd_req    = 1'b1;
                end
            endcase
        end
    end

endmodule

// File: rtl/qbp_pin_fsm.sv
module qbp_pin_fsm #(
    parameter int PULSE_CYC = 125,
    localparam int CW = (PULSE_CYC < 2) ? 1 : $clog2(PULSE_CYC)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic upd_en,
    input  logic new_bit,
    output logic latch_bit,
    output logic drv_weak,
    output logic drv_strong,
    output logic drv_down
);
    import qbp_pkg::*;

    localparam logic [CW-1:0] CNT_LOAD = CW'(PULSE_CYC - 1);

    pin_st_e       st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // next-state logic
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            PS_LOW: begin
                if (upd_en && new_bit) begin
                    st_d  = PS_BOOST;
                    cnt_d = CNT_LOAD;
                end
            end
            PS_BOOST: begin
                if (upd_en && !new_bit) begin
                    st_d  = PS_LOW;
                    cnt_d = '0;
                end else if (cnt_q == '0) begin
                    st_d  = PS_WEAK;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            PS_WEAK: begin
                if (upd_en && !new_bit) begin
                    st_d = PS_LOW;
                end
            end
            default: begin
                st_d  = PS_WEAK;
                cnt_d = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= PS_WEAK;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // outputs
    always_comb begin
        latch_bit  = 1'b1;
        drv_weak   = 1'b1;
        drv_strong = 1'b0;
        drv_down   = 1'b0;
        unique case (st_q)
            PS_LOW: begin
                latch_bit = 1'b0;
                drv_weak  = 1'b0;
                drv_down  = 1'b1;
            end
            PS_BOOST: begin
                drv_strong = 1'b1;
            end
            PS_WEAK: begin
                drv_weak = 1'b1;
            end
            default: begin
                drv_weak = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/qbp_sync.sv
module qbp_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '1;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/qbp_port.sv
module qbp_port #(
    parameter int W         = 8,
    parameter int PULSE_CYC = 125,
    parameter int SYNC_STG  = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cmd_valid,
    input  logic [1:0]   cmd_op,
    input  logic [W-1:0] cmd_data,
    output logic         rd_valid,
    output logic [W-1:0] rd_data,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] pull_weak,
    output logic [W-1:0] pull_strong,
    output logic [W-1:0] pull_down
);
    logic         upd_en;
    logic         rd_req;
    logic [W-1:0] latch_q;
    logic [W-1:0] latch_nxt;
    logic [W-1:0] pin_sync;

    qbp_cmd #(.W(W)) u_cmd (
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_data  (cmd_data),
        .latch_q   (latch_q),
        .upd_en    (upd_en),
        .rd_req    (rd_req),
        .latch_nxt (latch_nxt)
    );

    for (genvar b = 0; b < W; b++) begin : g_bit
        qbp_pin_fsm #(.PULSE_CYC(PULSE_CYC)) u_fsm (
            .clk        (clk),
            .rst_n      (rst_n),
            .upd_en     (upd_en),
            .new_bit    (latch_nxt[b]),
            .latch_bit  (latch_q[b]),
            .drv_weak   (pull_weak[b]),
            .drv_strong (pull_strong[b]),
            .drv_down   (pull_down[b])
        );
    end

    qbp_sync #(.W(W), .STAGES(SYNC_STG)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (pin_sync)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_req;
            if (rd_req) rd_data <= pin_sync;
        end
    end

endmodule

// File: rtl/qbp_port_chk.sv
module qbp_port_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         cmd_valid,
    input logic [1:0]   cmd_op,
    input logic [W-1:0] cmd_data,
    input logic         rd_valid,
    input logic [W-1:0] pull_weak,
    input logic [W-1:0] pull_strong,
    input logic [W-1:0] pull_down
);

    p_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pull_strong & pull_down) == '0);

    p_weak_under_strong_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pull_strong & ~pull_weak) == '0);

    p_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 2'b00) |=> pull_down == ~$past(cmd_data));

    p_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 2'b00) |=>
        (pull_strong & $past(pull_down & cmd_data)) == $past(pull_down & cmd_data));

    p_and_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 2'b01) |=> pull_down == $past(pull_down | ~cmd_data));

    p_or_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 2'b10) |=> pull_down == $past(pull_down & ~cmd_data));

    p_read_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 2'b11) |=> rd_valid);

    p_no_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid && cmd_op == 2'b11) |=> !rd_valid);

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_valid || cmd_op == 2'b11) |=>
        ($stable(pull_down) && (pull_strong & ~$past(pull_strong)) == '0));

endmodule

bind qbp_port qbp_port_chk #(.W(W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_op      (cmd_op),
    .cmd_data    (cmd_data),
    .rd_valid    (rd_valid),
    .pull_weak   (pull_weak),
    .pull_strong (pull_strong),
    .pull_down   (pull_down)
);

// File: tb/qbp_port_bench.sv
`timescale 1ns/1ps
module qbp_port_bench;
    localparam int W = 8;
    localparam int P = 125;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cmd_valid = 1'b0;
    logic [1:0]   cmd_op = 2'b00;
    logic [W-1:0] cmd_data = '0;
    logic         rd_valid;
    logic [W-1:0] rd_data;
    logic [W-1:0] pin_in;
    logic [W-1:0] pull_weak, pull_strong, pull_down;
    logic [W-1:0] ext_low = '0;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [W-1:0] exp_q [$];
    string        tag_q [$];

    always #2 clk = ~clk;

    // pad model: high through either pull-up unless something pulls low
    assign pin_in = (pull_weak | pull_strong) & ~pull_down & ~ext_low;

    qbp_port #(.W(W), .PULSE_CYC(P)) u_qbp_port (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_data(cmd_data), .rd_valid(rd_valid), .rd_data(rd_data),
        .pin_in(pin_in), .pull_weak(pull_weak), .pull_strong(pull_strong),
        .pull_down(pull_down)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cmd(input logic [1:0] op, input logic [W-1:0] d);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_data = d;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 2'b00; cmd_data = '0;
    endtask

    task automatic rd_expect(input logic [W-1:0] e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        cmd(2'b11, '0);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: pops expected reads as results appear
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                chk("R8 unexpected rd_valid", 1, 0);
            end else begin
                chk(tag_q.pop_front(), rd_data, exp_q.pop_front());
            end
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int n0, n1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 pull_weak", pull_weak, 8'hFF);
        chk("R1 pull_down", pull_down, 8'h00);
        chk("R1 pull_strong", pull_strong, 8'h00);
        chk("R1 rd_valid", rd_valid, 0);
        idle(3);
        rd_expect(8'hFF, "R8 read after reset");

        // R2 write zeros
        cmd(2'b00, 8'h00);
        chk("R2 pull_down", pull_down, 8'hFF);
        chk("R2 pull_weak", pull_weak, 8'h00);
        chk("R2 no strong", pull_strong, 8'h00);

        // R3 pulse length
        cmd(2'b00, 8'h0F);
        chk("R3 strong start", pull_strong, 8'h0F);
        chk("R3 pull_down", pull_down, 8'hF0);
        chk("R3 weak", pull_weak, 8'h0F);
        n0 = 0;
        while (pull_strong[0] && n0 < 2 * P) begin n0++; @(negedge clk); end
        chk("R3 pulse length", n0, P);
        chk("R3 weak after pulse", pull_weak, 8'h0F);

        // R4 no restart on repeated 1, fresh bit gets full pulse
        cmd(2'b00, 8'h00);
        cmd(2'b00, 8'h01);
        idle(5);
        cmd(2'b00, 8'h03);
        n0 = 0; n1 = 0;
        for (int k = 0; k < 2 * P; k++) begin
            if (pull_strong[0]) n0++;
            if (pull_strong[1]) n1++;
            @(negedge clk);
        end
        chk("R4 no restart bit0", n0, P - 7);
        chk("R4 fresh bit1 full", n1, P);
        cmd(2'b00, 8'h03);
        chk("R4 rewrite 1 no pulse", pull_strong, 8'h00);

        // R5 zero during pulse
        cmd(2'b00, 8'h00);
        cmd(2'b00, 8'h01);
        idle(2);
        cmd(2'b00, 8'h00);
        chk("R5 pulse cut", pull_strong, 8'h00);
        chk("R5 pulldown on", pull_down, 8'hFF);

        // R6 AND from latch
        cmd(2'b00, 8'hFF);
        idle(P + 2);
        ext_low = 8'h04;
        idle(3);
        cmd(2'b01, 8'hA5);
        chk("R6 and result", pull_down, 8'h5A);
        chk("R6 and no pulse", pull_strong, 8'h00);

        // R7 OR from latch while pin 0 held low externally
        ext_low = 8'h01;
        idle(3);
        cmd(2'b10, 8'h00);
        chk("R7 or keeps latch", pull_down, 8'h5A);
        cmd(2'b10, 8'h02);
        chk("R7 or result", pull_down, 8'h58);
        chk("R7 or rise pulse", pull_strong, 8'h02);

        // R9 mixed input and output bits
        idle(P + 3);
        rd_expect(8'hA6, "R9 mixed read A");
        ext_low = 8'h80;
        idle(3);
        rd_expect(8'h27, "R9 mixed read B");

        // R8 synchronizer latency
        idle(2);
        ext_low = 8'h00;
        rd_expect(8'h27, "R8 read before sync");
        rd_expect(8'hA7, "R8 read after sync");

        // R10 read and idle change nothing
        idle(2);
        chk("R10 latch after reads", pull_down, 8'h58);
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 2'b00; cmd_data = 8'hFF;
        @(negedge clk);
        cmd_data = '0;
        chk("R10 idle with data", pull_down, 8'h58);
        chk("R10 no pulse", pull_strong, 8'h00);
        chk("R10 read queue drained", exp_q.size(), 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule